// File: doc/BRIEF.md
# Interrupt Pending/Active State Controller

This block sits between a set of interrupt lines and a processor core. For every line it keeps two bits, pending and active. Together they give four states: inactive, pending, active, and active-and-pending. Each line is configured as level-sensitive or as pulse. The two kinds follow different rules when software clears a pending bit and when the handler returns. Inputs pass through a two-flop synchronizer before the state logic sees them. A pulse line latches on a rising edge. A level line is pending for as long as its input is high and it is not being serviced.

Software reaches the controller through a word-wide register port. The port has bitwise set and clear registers for enables and for pending state, a read-only active register, a line-kind register, a global delivery gate and a packed priority word. The controller offers the most urgent pending, enabled line to the processor with a request and a line number. It takes an acknowledge that makes that line active, and a return strobe that ends its handler. Only one line is active at a time; nesting is not supported.

Top module: `irq_state_ctrl`

## Requirements
- R1: After reset the enable, pending, active, kind and priority registers all read 0, the gate register reads 1 and no request is raised.
- R2: A line can become pending while its enable bit is 0, but a disabled line is never requested.
- R3: A level line (kind bit 0) becomes pending when its synchronized input is high and it is not active. Writing its clear-pending bit has no effect while the input is high, and makes it inactive once the input is low.
- R4: A pulse line (kind bit 1) latches pending on a rising edge of its synchronized input. Writing its clear-pending bit moves pending to inactive, and active-and-pending to active.
- R5: A rising edge on a pulse line that is active moves it to active-and-pending.
- R6: On the return strobe the active line becomes pending if it was active-and-pending, and inactive otherwise.
- R7: A request is raised only when no line is active, the gate is 1 and some line is both pending and enabled. The offered line has the lowest 2-bit priority value, and on a tie the lower line number wins.
- R8: An acknowledge while a request is up makes the offered line active and clears its pending bit on the next cycle. At most one line is ever active.
- R9: Writing 0 to bit 0 of the gate register drops the request without changing any pending bit. Writing 1 restores it.
- R10: An access with a nonzero address in bits [1:0] raises the error output, reads as 0 and changes no state.
- R11: Register words, at byte offsets: 0x00 enable-set, 0x04 enable-clear (both read the enable mask), 0x08 pending-set, 0x0C pending-clear (both read the pending mask), 0x10 active (read-only), 0x14 kind, 0x18 gate (bit 0), 0x1C priority (line i in bits [2i+1:2i]). A write to a set or clear register changes only the lines whose data bit is 1. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Raw interrupt lines |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Misaligned access |
| irq_req | output | 1 | Interrupt offered to the processor |
| irq_id | output | ID_W | Line number offered |
| irq_ack | input | 1 | Processor takes the offered line |
| irq_eret | input | 1 | Handler of the active line returns |

## Verification
The bench builds the block with its default of eight lines and an 8-bit address. That is enough to give two lines the same priority value so the tie-break shows. It also allows one level line and one pulse line to be driven side by side, and the gate and priority words then fit one register each. The reference model follows the synchronizer delay, so the bench can place pulses during a running handler. It can also clear pending bits while an input is still high, and observe the outcome at the request outputs on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PRIO_W = 2;
  localparam int DATA_W = 32;

  localparam int REG_EN_SET   = 0;
  localparam int REG_EN_CLR   = 1;
  localparam int REG_PEND_SET = 2;
  localparam int REG_PEND_CLR = 3;
  localparam int REG_ACTIVE   = 4;
  localparam int REG_KIND     = 5;
  localparam int REG_GATE     = 6;
  localparam int REG_PRIO     = 7;

  // lower value is more urgent; equal values keep the earlier choice
  function automatic logic outranks(input logic [PRIO_W-1:0] challenger,
                                    input logic [PRIO_W-1:0] holder);
    return challenger < holder;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] stage1, stage2, stage3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      stage3 <= '0;
    end else begin
      stage1 <= raw;
      stage2 <= stage1;
      stage3 <= stage2;
    end
  end

  assign lvl  = stage2;
  assign rise = stage2 & ~stage3;
endmodule

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic is_pulse,
  input  logic lvl,
  input  logic rise,
  input  logic set_pend,
  input  logic clr_pend,
  input  logic ack_hit,
  input  logic eret,
  output logic pend,
  output logic act
);
  logic pend_n, act_n;
  logic clear_takes, raise_evt;

  assign clear_takes = clr_pend && (is_pulse || !lvl);
  assign raise_evt   = set_pend || (is_pulse && rise) ||
                       (!is_pulse && lvl && !act && !ack_hit);

  always_comb begin
    act_n  = act;
    pend_n = pend;
    if (eret)        act_n  = 1'b0;
    if (ack_hit)     begin act_n = 1'b1; pend_n = 1'b0; end
    if (clear_takes) pend_n = 1'b0;
    if (raise_evt)   pend_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      act  <= 1'b0;
    end else begin
      pend <= pend_n;
      act  <= act_n;
    end
  end

  // level line held high ignores a clear-pending write
  assert_level_clear_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_pulse && clr_pend && lvl && pend && !ack_hit) |=> pend);

  // pulse line clear from active-and-pending leaves it active
  assert_pulse_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pulse && clr_pend && act && pend && !eret && !set_pend && !rise) |=> (act && !pend));

  assert_repulse_in_handler_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pulse && act && rise && !eret) |=> (act && pend));

  assert_return_repends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && act && pend && !clr_pend && !ack_hit) |=> (pend && !act));
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N    = 8,
  parameter int PW   = 2,
  parameter int IDW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  output logic            any,
  output logic [IDW-1:0]  id
);
  import irqc_pkg::*;

  logic [PW-1:0] best_p;

  always_comb begin
    any    = 1'b0;
    id     = '0;
    best_p = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || outranks(prio[i*PW +: PW], best_p))) begin
        any    = 1'b1;
        id     = IDW'(i);
        best_p = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_state_ctrl.sv
module irq_state_ctrl #(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINES-1:0]   irq_in,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic                 irq_req,
  output logic [ID_W-1:0]      irq_id,
  input  logic                 irq_ack,
  input  logic                 irq_eret
);
  import irqc_pkg::*;

  localparam int PW_ALL = N_LINES * PRIO_W;

  logic [N_LINES-1:0] en_q, kind_q, pend, act;
  logic [PW_ALL-1:0]  prio_q;
  logic               gate_q;

  logic               misaligned, wr_ok;
  logic [ADDR_W-3:0]  word;
  logic [N_LINES-1:0] wbits, set_vec, clr_vec, ack_vec, cand;
  logic [N_LINES-1:0] lvl, rise;
  logic               pick_any, take;
  logic               wdata_unused;

  assign misaligned   = bus_valid && (bus_addr[1:0] != 2'b00);
  assign wr_ok        = bus_valid && bus_write && !misaligned;
  assign word         = bus_addr[ADDR_W-1:2];
  assign wbits        = bus_wdata[N_LINES-1:0];
  assign wdata_unused = ^bus_wdata[DATA_W-1:PW_ALL];
  assign bus_err      = misaligned;

  assign set_vec = (wr_ok && int'(word) == REG_PEND_SET) ? wbits : '0;
  assign clr_vec = (wr_ok && int'(word) == REG_PEND_CLR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      kind_q <= '0;
      prio_q <= '0;
      gate_q <= 1'b1;
    end else if (wr_ok) begin
      case (int'(word))
        REG_EN_SET: en_q   <= en_q | wbits;
        REG_EN_CLR: en_q   <= en_q & ~wbits;
        REG_KIND:   kind_q <= wbits;
        REG_GATE:   gate_q <= bus_wdata[0];
        REG_PRIO:   prio_q <= bus_wdata[PW_ALL-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !misaligned) begin
      case (int'(word))
        REG_EN_SET, REG_EN_CLR:     bus_rdata = DATA_W'(en_q);
        REG_PEND_SET, REG_PEND_CLR: bus_rdata = DATA_W'(pend);
        REG_ACTIVE:                 bus_rdata = DATA_W'(act);
        REG_KIND:                   bus_rdata = DATA_W'(kind_q);
        REG_GATE:                   bus_rdata = DATA_W'(gate_q);
        REG_PRIO:                   bus_rdata = DATA_W'(prio_q);
        default: ;
      endcase
    end
  end

  irqc_sync #(.W(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .lvl(lvl), .rise(rise)
  );

  assign cand = pend & en_q;

  irqc_pick #(.N(N_LINES), .PW(PRIO_W), .IDW(ID_W)) u_pick (
    .cand(cand), .prio(prio_q), .any(pick_any), .id(irq_id)
  );

  assign irq_req = gate_q && (act == '0) && pick_any;
  assign take    = irq_ack && irq_req;
  assign ack_vec = take ? (N_LINES'(1) << irq_id) : '0;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irqc_line u_line (
      .clk(clk), .rst_n(rst_n),
      .is_pulse(kind_q[g]), .lvl(lvl[g]), .rise(rise[g]),
      .set_pend(set_vec[g]), .clr_pend(clr_vec[g]),
      .ack_hit(ack_vec[g]), .eret(irq_eret),
      .pend(pend[g]), .act(act[g])
    );

    assert_no_better_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && cand[g]) |->
        ((prio_q[irq_id*PRIO_W +: PRIO_W] < prio_q[g*PRIO_W +: PRIO_W]) ||
         ((prio_q[irq_id*PRIO_W +: PRIO_W] == prio_q[g*PRIO_W +: PRIO_W]) && (int'(irq_id) <= g))));
  end

  assert_offer_is_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_q[irq_id] && pend[irq_id]));

  assert_single_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  assert_ack_activates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> act[$past(irq_id)]);

  assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gate_q);

  assert_misaligned_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |=> ($stable(en_q) && $stable(kind_q) && $stable(prio_q) && $stable(gate_q)));

  assert_return_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_eret && !take) |=> (act == '0));
endmodule

// File: tb/irq_state_ctrl_test.sv
module irq_state_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err, irq_req;
  logic [IDW-1:0] irq_id;
  logic irq_ack = 1'b0, irq_eret = 1'b0;

  int checks = 0, fails = 0;
  bit compare_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_state_ctrl #(.N_LINES(N), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_req(irq_req), .irq_id(irq_id), .irq_ack(irq_ack), .irq_eret(irq_eret)
  );

  // ---------------- reference model ----------------
  bit [N-1:0] m_en, m_kind, m_pend, m_act, m_d1, m_d2, m_d3, np, na, ackv;
  bit [15:0]  m_prio;
  bit         m_gate;
  int         mw, wd;
  bit         mrq, wr;

  function automatic int m_winner();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i])
        if (best < 0 || m_prio[2*i +: 2] < m_prio[2*best +: 2]) best = i;
    return best;
  endfunction

  function automatic bit m_req();
    return m_gate && (m_act == 0) && (m_winner() >= 0);
  endfunction

  function automatic logic [31:0] m_read(int w);
    case (w)
      0, 1: return 32'(m_en);
      2, 3: return 32'(m_pend);
      4:    return 32'(m_act);
      5:    return 32'(m_kind);
      6:    return 32'(m_gate);
      7:    return 32'(m_prio);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_kind = 0; m_pend = 0; m_act = 0; m_prio = 0; m_gate = 1;
      m_d1 = 0; m_d2 = 0; m_d3 = 0;
    end else begin
      mw = m_winner();
      mrq = m_req();
      ackv = 0;
      if (irq_ack && mrq) ackv[mw] = 1'b1;
      wr = bus_valid && bus_write && (bus_addr % 4 == 0);
      wd = bus_addr / 4;
      for (int i = 0; i < N; i++) begin
        np[i] = m_pend[i];
        na[i] = m_act[i];
        if (irq_eret) na[i] = 1'b0;
        if (ackv[i]) begin na[i] = 1'b1; np[i] = 1'b0; end
        if (wr && wd == 3 && bus_wdata[i] && (m_kind[i] || !m_d2[i])) np[i] = 1'b0;
        if ((wr && wd == 2 && bus_wdata[i]) ||
            (m_kind[i] && m_d2[i] && !m_d3[i]) ||
            (!m_kind[i] && m_d2[i] && !m_act[i] && !ackv[i])) np[i] = 1'b1;
      end
      m_pend = np;
      m_act  = na;
      if (wr) begin
        if (wd == 0) m_en = m_en | bus_wdata[N-1:0];
        if (wd == 1) m_en = m_en & ~bus_wdata[N-1:0];
        if (wd == 5) m_kind = bus_wdata[N-1:0];
        if (wd == 6) m_gate = bus_wdata[0];
        if (wd == 7) m_prio = bus_wdata[15:0];
      end
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = irq_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison of the processor-side outputs (R7, R8)
  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      chk("R7 request", 32'(irq_req), 32'(m_req()));
      if (m_req()) chk("R7 offered line", 32'(irq_id), 32'(m_winner()));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, m_read(a / 4));
    chk({tag, " no error"}, 32'(bus_err), 32'h0);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic pulse(input int line);
    @(negedge clk); irq_in[line] = 1'b1;
    @(negedge clk); irq_in[line] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic eret();
    @(negedge clk); irq_eret = 1'b1;
    @(negedge clk); irq_eret = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_on = 1'b1;

    // R1 reset state
    rd_lit(8'h00, 32'h0, "R1 enable");
    rd_lit(8'h08, 32'h0, "R1 pending");
    rd_lit(8'h10, 32'h0, "R1 active");
    rd_lit(8'h14, 32'h0, "R1 kind");
    rd_lit(8'h18, 32'h1, "R1 gate");
    rd_lit(8'h1C, 32'h0, "R1 priority");
    chk("R1 no request", 32'(irq_req), 32'h0);

    // R2 / R3: level line 2, disabled, input high
    @(negedge clk); irq_in[2] = 1'b1;
    idle(4);
    rd_lit(8'h08, 32'h4, "R2 pending while disabled");
    chk("R2 disabled not requested", 32'(irq_req), 32'h0);
    wr_reg(8'h0C, 32'h4);
    rd_lit(8'h08, 32'h4, "R3 clear ignored while high");
    @(negedge clk); irq_in[2] = 1'b0;
    idle(4);
    wr_reg(8'h0C, 32'h4);
    rd_lit(8'h08, 32'h0, "R3 clear after input low");

    // R4: pulse line 5
    wr_reg(8'h14, 32'h20);
    pulse(5);
    idle(4);
    rd_lit(8'h08, 32'h20, "R4 pulse latched");
    wr_reg(8'h0C, 32'h20);
    rd_lit(8'h08, 32'h0, "R4 pulse cleared");

    // R11 / R7: enables, priorities, set-pending
    wr_reg(8'h00, 32'hFF);
    wr_reg(8'h04, 32'h81);
    rd_lit(8'h00, 32'h7E, "R11 enable set/clear bitwise");
    wr_reg(8'h00, 32'h02);
    wr_reg(8'h1C, 32'h1000 | 32'h0040 | 32'h0008);
    rd_reg(8'h1C, "R11 priority readback");
    wr_reg(8'h08, 32'h4A);
    rd_lit(8'h08, 32'h4A, "R11 set-pending bitwise");
    idle(1);
    chk("R7 tie goes to lower line", 32'(irq_id), 32'h3);

    // R9 gate
    wr_reg(8'h18, 32'h0);
    idle(1);
    chk("R9 gate drops request", 32'(irq_req), 32'h0);
    rd_lit(8'h08, 32'h4A, "R9 pending kept");
    wr_reg(8'h18, 32'h1);
    idle(1);
    chk("R9 gate restores request", 32'(irq_req), 32'h1);

    // R8 acknowledge and R6 plain return
    ack();
    rd_lit(8'h10, 32'h8, "R8 line 3 active");
    rd_lit(8'h08, 32'h42, "R8 pending cleared on ack");
    chk("R8 no request while active", 32'(irq_req), 32'h0);
    eret();
    rd_lit(8'h10, 32'h0, "R6 return to inactive");
    chk("R7 next line offered", 32'(irq_id), 32'h6);
    ack();
    eret();

    // R5 / R4 / R6 on pulse line 5 (priority 0)
    pulse(5);
    idle(4);
    chk("R7 urgent pulse line offered", 32'(irq_id), 32'h5);
    ack();
    pulse(5);
    idle(4);
    rd_lit(8'h10, 32'h20, "R5 still active");
    rd_lit(8'h08, 32'h22, "R5 active and pending");
    wr_reg(8'h0C, 32'h20);
    rd_lit(8'h10, 32'h20, "R4 active kept after clear");
    rd_lit(8'h08, 32'h02, "R4 pending dropped from active-and-pending");
    pulse(5);
    idle(4);
    eret();
    rd_lit(8'h08, 32'h22, "R6 re-pending after return");
    rd_lit(8'h10, 32'h0, "R6 not active after return");
    chk("R6 line offered again", 32'(irq_id), 32'h5);
    ack();
    eret();
    rd_reg(8'h08, "R6 pending after second return");
    ack();
    eret();

    // R3 level line in handler
    @(negedge clk); irq_in[2] = 1'b1;
    idle(4);
    ack();
    rd_reg(8'h08, "R3 level not pending while active");
    eret();
    idle(2);
    rd_lit(8'h08, 32'h04, "R3 level re-pends after return");
    @(negedge clk); irq_in[2] = 1'b0;
    idle(4);
    wr_reg(8'h0C, 32'h04);
    rd_lit(8'h08, 32'h0, "R3 level cleared");

    // R10 misaligned
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 8'h05; bus_wdata = 32'hFFFF_FFFF;
    #1;
    chk("R10 write error flag", 32'(bus_err), 32'h1);
    @(negedge clk);
    bus_addr = 8'h02; bus_write = 0;
    #1;
    chk("R10 read error flag", 32'(bus_err), 32'h1);
    chk("R10 read data zero", bus_rdata, 32'h0);
    @(negedge clk);
    bus_valid = 0;
    rd_lit(8'h00, 32'h7E, "R10 enable unchanged");
    rd_lit(8'h1C, 32'h1048, "R10 priority unchanged");

    // R11 unmapped offset
    wr_reg(8'h40, 32'hFFFF_FFFF);
    rd_lit(8'h40, 32'h0, "R11 unmapped reads zero");
    rd_lit(8'h14, 32'h20, "R11 unmapped write ignored");

    idle(3);
    finish_run();
  end
endmodule